// File: doc/BRIEF.md
# Two-Line Write-Through Data Cache

This block is a small fully associative data cache that sits between a processor load/store port and a word-addressed backing memory. It holds two lines of two words each. A 5-bit word address splits into a 4-bit line tag (upper bits) and a 1-bit word offset (bit 0). Any miss, whether a load or a store, brings the complete line in from memory before the access finishes. The victim line is chosen by least-recently-used order.

Stores follow a write-through, write-allocate policy. A store that misses first allocates and fills the line, then merges the new word into it. Every store, hit or miss, then sends exactly that one word to memory. A cached line therefore never differs from memory, so lines carry no modified flag and an eviction never produces a memory write. Two counters record how many completed accesses hit and how many missed.

The processor raises `cpu_req` with address, direction and write data, and holds them until it sees a one-cycle `cpu_ready` pulse. Load data is valid on `cpu_rdata` in that cycle. On the memory side, each word read and each word write is a request that stays high until memory returns its acknowledge in a cycle where the request is high.

Top module: `wtc_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low and both counters read zero. Reset leaves every line invalid, so the first access after reset is a miss. The replacement pointer starts at line 0.
- R2: A load whose tag matches a valid line makes no memory request. It pulses `cpu_ready` with the cached word for the requested offset.
- R3: A miss issues exactly two word reads. Both use the requested tag, the first with offset 0 and the second with offset 1. The second read is not issued before the first is acknowledged.
- R4: A load that misses returns, with its `cpu_ready` pulse, the memory word at its own address.
- R5: Every store issues exactly one memory write, carrying the store's own address and data. It raises no `cpu_ready` until that write is acknowledged. A memory read and a memory write are never requested in the same cycle.
- R6: A store that misses leaves its line allocated. A later load of the stored address returns the stored data without a memory read. A later load of the other word of that line returns the memory value, also without a read.
- R7: An eviction makes no memory write: a load makes no memory write even when it replaces a valid line.
- R8: On a miss the line replaced is the one used less recently. Both a hit and a fill make the touched line the most recently used.
- R9: Each completed access adds exactly one to either `hit_count` or `miss_count`, in the cycle after its `cpu_ready` pulse. At all other times the counters hold.
- R10: `cpu_ready` is high for exactly one cycle per access. It is raised only after every memory read and write of that access has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: tag in the upper bits, offset in bit 0 |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle access completion pulse |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_addr | output | ADDR_W | Word read address |
| mem_rd_data | input | DATA_W | Read data, valid with `mem_rd_ack` |
| mem_rd_ack | input | 1 | Read acknowledge |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_addr | output | ADDR_W | Word write address |
| mem_wr_data | output | DATA_W | Word write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| hit_count | output | CNT_W | Completed accesses that hit |
| miss_count | output | CNT_W | Completed accesses that missed |

## Verification
A store that misses must merge its word after the fill. If it merged before, the fill would overwrite the store data and the later load would return stale memory. Each address is stored and then read back together with its neighbouring word, so a design that skips allocation would show extra memory reads. The replacement order is driven through a hit-then-miss pattern, where a design that picks a fixed victim or ignores hits evicts the wrong line and misses where the bench predicts a hit. Memory acknowledge latency is varied from zero to three cycles, so a design that raises `cpu_ready` before the write-through or the second fill word is acknowledged shows up as a short transfer count or wrong data.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_STORE = 2'd2,
      ST_RESP  = 2'd3
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
   parameter int LINES = 2,
   parameter int TAG_W = 4,
   parameter int IDX_W = 1
) (
   input  logic [LINES-1:0]            valid,
   input  logic [LINES-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]            look_tag,
   output logic                        hit,
   output logic [IDX_W-1:0]            hit_idx
);
   logic [LINES-1:0] match;

   for (genvar i = 0; i < LINES; i++) begin : g_cmp
      assign match[i] = valid[i] && (tags[i] == look_tag);
   end

   assign hit = |match;

   always_comb begin
      hit_idx = '0;
      for (int k = 0; k < LINES; k++) begin
         if (match[k]) hit_idx = IDX_W'(k);
      end
   end
endmodule

// File: rtl/wtc_line_array.sv
module wtc_line_array #(
   parameter int LINES  = 2,
   parameter int WORDS  = 2,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 1,
   parameter int OFF_W  = 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   alloc_en,
   input  logic [IDX_W-1:0]                       alloc_idx,
   input  logic [TAG_W-1:0]                       alloc_tag,
   input  logic                                   fin_en,
   input  logic [IDX_W-1:0]                       fin_idx,
   input  logic                                   wr_en,
   input  logic [IDX_W-1:0]                       wr_idx,
   input  logic [OFF_W-1:0]                       wr_off,
   input  logic [DATA_W-1:0]                      wr_data,
   output logic [LINES-1:0]                       valid_o,
   output logic [LINES-1:0][TAG_W-1:0]            tags_o,
   output logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] data_o
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic                          v;
      logic [TAG_W-1:0]              t;
      logic [WORDS-1:0][DATA_W-1:0]  d;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v <= 1'b0;
            t <= '0;
            d <= '0;
         end else begin
            if (alloc_en && alloc_idx == IDX_W'(i)) begin
               v <= 1'b0;
               t <= alloc_tag;
            end
            if (fin_en && fin_idx == IDX_W'(i)) v <= 1'b1;
            if (wr_en && wr_idx == IDX_W'(i)) d[wr_off] <= wr_data;
         end
      end

      assign valid_o[i] = v;
      assign tags_o[i]  = t;
      assign data_o[i]  = d;
   end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
   parameter int ADDR_W = 5,
   parameter int OFF_W  = 1,
   parameter int DATA_W = 8,
   parameter int LINES  = 2,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   input  logic              mem_rd_ack,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   import wtc_pkg::*;

   localparam int TAG_W = ADDR_W - OFF_W;
   localparam int WORDS = 1 << OFF_W;
   localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

   if (LINES != 2) begin : g_bad_lines
      $error("wtc_cache: replacement order supports exactly two lines");
   end
   if (OFF_W < 1 || ADDR_W <= OFF_W) begin : g_bad_addr
      $error("wtc_cache: address must hold a tag and at least one offset bit");
   end

   wtc_state_e           state;
   logic [ADDR_W-1:0]    req_addr;
   logic                 req_we;
   logic [DATA_W-1:0]    req_wdata;
   logic [IDX_W-1:0]     victim;
   logic [IDX_W-1:0]     lru;
   logic [OFF_W-1:0]     beat;
   logic                 miss_f;
   logic [DATA_W-1:0]    rdata_q;
   logic [CNT_W-1:0]     hit_q, miss_q;

   logic [TAG_W-1:0]     cpu_tag, req_tag;
   logic [OFF_W-1:0]     cpu_off, req_off;
   logic                 hit;
   logic [IDX_W-1:0]     hit_idx;
   logic [LINES-1:0]     valid_v;
   logic [LINES-1:0][TAG_W-1:0]             tags_v;
   logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] data_v;

   logic                 alloc_en, fin_en, wr_en;
   logic [IDX_W-1:0]     wr_idx;
   logic [OFF_W-1:0]     wr_off;
   logic [DATA_W-1:0]    wr_data;
   logic                 start;

   assign cpu_tag = cpu_addr[ADDR_W-1:OFF_W];
   assign cpu_off = cpu_addr[OFF_W-1:0];
   assign req_tag = req_addr[ADDR_W-1:OFF_W];
   assign req_off = req_addr[OFF_W-1:0];
   assign start   = (state == ST_IDLE) && cpu_req;

   wtc_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
      .valid(valid_v), .tags(tags_v), .look_tag(cpu_tag),
      .hit(hit), .hit_idx(hit_idx)
   );

   always_comb begin
      alloc_en = start && !hit;
      fin_en   = (state == ST_FILL) && mem_rd_ack && (beat == LAST_OFF);
      wr_en    = (start && hit && cpu_we) || ((state == ST_FILL) && mem_rd_ack);
      if (state == ST_FILL) begin
         wr_idx  = victim;
         wr_off  = beat;
         wr_data = (req_we && beat == req_off) ? req_wdata : mem_rd_data;
      end else begin
         wr_idx  = hit_idx;
         wr_off  = cpu_off;
         wr_data = cpu_wdata;
      end
   end

   wtc_line_array #(
      .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W),
      .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) u_lines (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_idx(lru), .alloc_tag(cpu_tag),
      .fin_en(fin_en), .fin_idx(victim),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
      .valid_o(valid_v), .tags_o(tags_v), .data_o(data_v)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         req_addr  <= '0;
         req_we    <= 1'b0;
         req_wdata <= '0;
         victim    <= '0;
         lru       <= '0;
         beat      <= '0;
         miss_f    <= 1'b0;
         rdata_q   <= '0;
         hit_q     <= '0;
         miss_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (cpu_req) begin
               req_addr  <= cpu_addr;
               req_we    <= cpu_we;
               req_wdata <= cpu_wdata;
               if (hit) begin
                  lru     <= ~hit_idx;
                  miss_f  <= 1'b0;
                  rdata_q <= cpu_we ? cpu_wdata : data_v[hit_idx][cpu_off];
                  state   <= cpu_we ? ST_STORE : ST_RESP;
               end else begin
                  victim <= lru;
                  beat   <= '0;
                  miss_f <= 1'b1;
                  state  <= ST_FILL;
               end
            end
            ST_FILL: if (mem_rd_ack) begin
               if (beat == req_off) rdata_q <= req_we ? req_wdata : mem_rd_data;
               if (beat == LAST_OFF) begin
                  lru   <= ~victim;
                  state <= req_we ? ST_STORE : ST_RESP;
               end else begin
                  beat <= beat + OFF_W'(1);
               end
            end
            ST_STORE: if (mem_wr_ack) state <= ST_RESP;
            ST_RESP: begin
               if (miss_f) miss_q <= miss_q + CNT_W'(1);
               else        hit_q  <= hit_q + CNT_W'(1);
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready   = (state == ST_RESP);
   assign cpu_rdata   = rdata_q;
   assign mem_rd_req  = (state == ST_FILL);
   assign mem_rd_addr = {req_tag, beat};
   assign mem_wr_req  = (state == ST_STORE);
   assign mem_wr_addr = req_addr;
   assign mem_wr_data = req_wdata;
   assign hit_count   = hit_q;
   assign miss_count  = miss_q;
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
   parameter int ADDR_W = 5,
   parameter int OFF_W  = 1,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_ready,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ack,
   input logic              mem_wr_req,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((1 << OFF_W) - 1);
   logic [CNT_W:0] total;
   assign total = {1'b0, hit_count} + {1'b0, miss_count};

   p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   p_store_item_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> (cpu_we && mem_wr_addr == cpu_addr && mem_wr_data == cpu_wdata));

   p_fill_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

   p_fill_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_ack && mem_rd_addr[OFF_W-1:0] != LAST_OFF)
      |=> (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1)));

   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> (total == $past(total) + (CNT_W+1)'(1)));

   p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ready |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind wtc_cache wtc_cache_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
   .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
   .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
   .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_wtc_cache.sv
`timescale 1ns/1ps
module sim_wtc_cache;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 1'b0, cpu_we = 1'b0;
   logic [4:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       cpu_ready;
   logic       mem_rd_req, mem_wr_req;
   logic [4:0] mem_rd_addr, mem_wr_addr;
   logic [7:0] mem_rd_data = '0, mem_wr_data;
   logic       mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
   logic [15:0] hit_count, miss_count;

   always #2 clk = ~clk;

   wtc_cache u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .mem_rd_ack(mem_rd_ack), .mem_wr_req(mem_wr_req),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   int checks = 0, errors = 0;
   logic [7:0] mem_m [32];
   int rd_n, wr_n, lat, wait_c;
   int rd_log [4];
   int wr_a, wr_d;
   logic       m_valid [2];
   logic [3:0] m_tag [2];
   int m_lru, exp_hits, exp_miss;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // memory model: answers requests after lat idle cycles
   always @(negedge clk) begin
      mem_rd_ack = 1'b0;
      mem_wr_ack = 1'b0;
      if (rst_n) begin
         if (mem_rd_req) begin
            if (wait_c >= lat) begin
               mem_rd_ack = 1'b1;
               mem_rd_data = mem_m[mem_rd_addr];
               if (rd_n < 4) rd_log[rd_n] = int'(mem_rd_addr);
               rd_n++;
               wait_c = 0;
            end else wait_c++;
         end else if (mem_wr_req) begin
            if (wait_c >= lat) begin
               mem_wr_ack = 1'b1;
               mem_m[mem_wr_addr] = mem_wr_data;
               wr_a = int'(mem_wr_addr);
               wr_d = int'(mem_wr_data);
               wr_n++;
               wait_c = 0;
            end else wait_c++;
         end
      end
   end

   task automatic access(input bit we, input int addr, input int wdata);
      bit exp_hit;
      int line, cyc, exp_rd;
      logic [3:0] tg;
      tg = 4'(addr >> 1);
      exp_hit = 0; line = 0;
      for (int i = 0; i < 2; i++)
         if (m_valid[i] && m_tag[i] == tg) begin exp_hit = 1; line = i; end
      if (!exp_hit) begin
         line = m_lru; m_valid[line] = 1; m_tag[line] = tg;
      end
      m_lru = 1 - line;
      if (exp_hit) exp_hits++; else exp_miss++;
      exp_rd = int'(mem_m[addr]);
      @(negedge clk);
      rd_n = 0; wr_n = 0; wait_c = 0;
      cpu_req = 1; cpu_we = we; cpu_addr = 5'(addr); cpu_wdata = 8'(wdata);
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (!cpu_ready && cyc < 500);
      chk(cpu_ready, "R10 ready timeout", cyc, 0);
      chk(rd_n == (exp_hit ? 0 : 2), exp_hit ? "R8 hit predicted, reads" : "R3 block reads", rd_n, exp_hit ? 0 : 2);
      if (!exp_hit && rd_n == 2) begin
         chk(rd_log[0] == ((addr >> 1) << 1), "R3 first read offset 0", rd_log[0], (addr >> 1) << 1);
         chk(rd_log[1] == (((addr >> 1) << 1) | 1), "R3 second read offset 1", rd_log[1], ((addr >> 1) << 1) | 1);
      end
      if (we) begin
         chk(wr_n == 1, "R5 one write-through", wr_n, 1);
         chk(wr_a == addr && wr_d == (wdata & 255), "R5 write address/data", wr_d, wdata & 255);
      end else begin
         chk(wr_n == 0, "R7 no memory write on load", wr_n, 0);
         chk(int'(cpu_rdata) == exp_rd, exp_hit ? "R2 hit data" : "R4 miss data", int'(cpu_rdata), exp_rd);
      end
      cpu_req = 0;
      @(negedge clk);
      chk(!cpu_ready, "R10 ready single cycle", int'(cpu_ready), 0);
      chk(int'(hit_count) == exp_hits, "R9 hit counter", int'(hit_count), exp_hits);
      chk(int'(miss_count) == exp_miss, "R9 miss counter", int'(miss_count), exp_miss);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem_m[i] = 8'(i * 37 + 5);
      m_valid[0] = 0; m_valid[1] = 0; m_tag[0] = 0; m_tag[1] = 0;
      m_lru = 0; exp_hits = 0; exp_miss = 0; lat = 1; rd_n = 0; wr_n = 0; wait_c = 0;
      repeat (4) @(negedge clk);
      chk(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1 outputs in reset", int'(cpu_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1 idle after reset", int'(mem_rd_req), 0);
      chk(hit_count == 0 && miss_count == 0, "R1 counters cleared", int'(hit_count + miss_count), 0);
      // worked sequence
      access(0, 1, 0);
      chk(rd_n == 2, "R1 first access misses", rd_n, 2);
      access(0, 7, 0);
      access(1, 0, 173);
      access(1, 5, 29);
      access(0, 10, 0);
      access(0, 5, 0);
      access(1, 10, 29);
      access(1, 5, 44);
      access(1, 10, 91);
      // R8 order: hit refreshes recency
      access(0, 0, 0); access(0, 2, 0); access(0, 1, 0);
      access(0, 4, 0); access(0, 0, 0); access(0, 3, 0);
      // R6 store-miss allocate over every address
      lat = 0;
      for (int a = 0; a < 32; a++) begin
         access(1, a, (a * 13 + 200));
         access(0, a, 0);
         access(0, a ^ 1, 0);
      end
      // mixed sweep with varied memory latency
      begin
         int s;
         s = 7;
         for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int n = 0; n < 60; n++) begin
               s = (s * 1103515245 + 12345) & 32'h7fffffff;
               access(s[20], (s >> 4) & 31, (s >> 12) & 255);
            end
         end
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         chk(0, "R10 watchdog expired", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule